// File: doc/BRIEF.md
# Chip-Select and DRAM Strobe Decoder

This block turns a 20-bit bus address into active-low select lines. It drives three memory windows: low, middle and high. It drives a run of peripheral selects, and it drives the row and column strobes of two DRAM banks. For each bus cycle it also reports the wait-state count and the data-bus width. A cycle starts on a one-clock address-latch pulse, and every decoded result is captured at that clock edge. The results then hold until the next start. The column strobes are further gated by the live read or write strobe.

Two overlap rules apply. A peripheral select may sit on top of a DRAM bank. In that case the bank's row strobe fires together with the peripheral select, but neither column strobe fires, so the DRAM neither drives nor stores data. Any other overlap is settled by a fixed priority and is flagged. While an external master holds the bus, every select and strobe is forced inactive. A boot-width strap is captured while reset is low and is frozen when reset releases. That strap decides whether the high window's width can be programmed at all.

Top module: `cs_dram_decoder`

## Requirements
- R1: Region 0 (low), region 1 (middle) and region 2 (high) each hit a memory-space address (`mem_space_i`=1) when the region's enable bit is set and lo <= address <= hi, both bounds inclusive. A hit drives `lcs_no`, `mcs_no` or `ucs_no` low. I/O cycles never hit these regions.
- R2: Peripheral select k (0..NP-1) hits when `pcs_en_i`=1, the address lies in block k of the 256-byte blocks that start at `pcs_base_i` (base aligned down to 256), and the space matches. With `pcs_io_i`=1 the selects respond to I/O cycles only; with 0 they respond to memory cycles only. Bit k of `pcs_no` goes low.
- R3: A memory address inside an enabled DRAM bank b (inclusive bounds) drives `ras_no[b]` low. `lcas_no` goes low only when `ben_i[0]`=1, and `ucas_no` only when `ben_i[1]`=1. Each column strobe also requires `rd_i` or `wr_i` to be high.
- R4: When exactly one DRAM bank and exactly one peripheral select hit, and no region 0-2 hits, both strobes assert: the bank's `ras_no` bit and the `pcs_no` bit. `lcas_no` and `ucas_no` both stay high.
- R5: In the R4 case, the cycle's width follows address bit 19: 0 selects region 0's width bit, 1 selects the effective high-region width. If the peripheral wait count is below the bank's, `cfg_err_o`=1 and `ws_o` is the bank's count. Otherwise `cfg_err_o`=0 and `ws_o` is the peripheral count.
- R6: With a single winner, `ws_o` and `wide_o` (1 = 16-bit) come from that winner's settings. Regions 0 and 1 use `mem_wide_i[0]` and `mem_wide_i[1]`, and region 2 uses its effective width. DRAM uses `dram_wide_i`. A peripheral select uses the R5 address-bit rule in memory space and `io_wide_i` in I/O space. With no hit, `ws_o`=0 and the width follows the same space-dependent rule.
- R7: Any other overlap is won by the lowest index, in the order region 0, 1, 2, DRAM bank 0..NB-1, then peripheral select 0..NP-1. Only the winner asserts, and `overlap_o`=1. Otherwise `overlap_o`=0.
- R8: While `hold_ack_i`=1, all select, row and column outputs are high, and an address-latch pulse does not start a cycle. When hold ends, the decode captured before the hold reappears.
- R9: `boot_wide_o` equals `boot_strap_i` as it stood when reset was released, and it does not change until the next reset.
- R10: The effective high-region width is 16-bit whenever `boot_wide_o`=1. Only after an 8-bit boot does it follow `mem_wide_i[2]`.
- R11: Selects, strobe enables, `ws_o`, `wide_o`, `overlap_o` and `cfg_err_o` update only at a clock edge where `ale_i`=1 and hold is low. Changes to the address or configuration at other times have no effect on these outputs.
- R12: While reset is low, all select and strobe outputs are high, and `ws_o`, `wide_o`, `overlap_o` and `cfg_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_strap_i | input | 1 | Boot-width strap (1 = 16-bit) |
| addr_i | input | AW | Bus address |
| mem_space_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| ben_i | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ale_i | input | 1 | Cycle-start pulse |
| hold_ack_i | input | 1 | Bus granted to external master |
| mem_lo_i | input | 3 x AW | Lower bound of regions 0..2 |
| mem_hi_i | input | 3 x AW | Upper bound of regions 0..2 |
| mem_en_i | input | 3 | Region enables |
| mem_ws_i | input | 3 x WSW | Region wait counts |
| mem_wide_i | input | 3 | Region width bits (1 = 16-bit) |
| io_wide_i | input | 1 | I/O space width bit |
| dram_lo_i | input | NB x AW | DRAM bank lower bounds |
| dram_hi_i | input | NB x AW | DRAM bank upper bounds |
| dram_en_i | input | NB | DRAM bank enables |
| dram_ws_i | input | NB x WSW | DRAM bank wait counts |
| dram_wide_i | input | NB | DRAM bank width bits |
| pcs_base_i | input | AW | Peripheral block base |
| pcs_io_i | input | 1 | Peripheral selects in I/O space |
| pcs_en_i | input | 1 | Peripheral select enable |
| pcs_ws_i | input | WSW | Peripheral wait count |
| lcs_no | output | 1 | Region 0 select |
| mcs_no | output | 1 | Region 1 select |
| ucs_no | output | 1 | Region 2 select |
| pcs_no | output | NP | Peripheral selects |
| ras_no | output | NB | DRAM row strobes |
| lcas_no | output | 1 | Low-byte column strobe |
| ucas_no | output | 1 | High-byte column strobe |
| ws_o | output | WSW | Effective wait count |
| wide_o | output | 1 | Effective width (1 = 16-bit) |
| overlap_o | output | 1 | Priority overlap flag |
| cfg_err_o | output | 1 | Peripheral wait count below DRAM count |
| boot_wide_o | output | 1 | Latched boot width |

## Verification
On every cycle, the assertions check four things. Hold forces all lines inactive. A DRAM/peripheral pair never drives a column strobe. At most one non-DRAM select is low. The registered results stay still without a cycle start. Further cycle-by-cycle checks cover the gating of column strobes by the read and write strobes, the link between the error flag and a live pair, and the stability of the boot width. The address decode itself, the priority winner, the wait-count and width choice, and the strap effect on the high region can only be shown by the bench. It does this by driving chosen addresses and configurations and comparing against its reference model.

// File: rtl/cs_dram_pkg.sv
package cs_dram_pkg;
  localparam int unsigned ADDR_W_D  = 20;
  localparam int unsigned BANKS_D   = 2;
  localparam int unsigned PCS_D     = 4;
  localparam int unsigned PCS_BLK_D = 8;   // log2 of peripheral block size
  localparam int unsigned WS_W_D    = 4;
  localparam int unsigned FIX_REGS  = 3;   // low, middle, high windows

  function automatic logic in_window(input logic [ADDR_W_D-1:0] a,
                                     input logic [ADDR_W_D-1:0] lo,
                                     input logic [ADDR_W_D-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/cs_boot_latch.sv
module cs_boot_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_strap_i,
  output logic boot_wide_o
);
  // tracks the strap while reset is low, frozen from release onward
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_wide_o <= boot_strap_i;
  end
endmodule

// File: rtl/cs_region_match.sv
module cs_region_match import cs_dram_pkg::*; #(
  parameter int unsigned NB = BANKS_D,
  parameter int unsigned NP = PCS_D,
  parameter int unsigned PB = PCS_BLK_D,
  localparam int unsigned AW = ADDR_W_D,
  localparam int unsigned NR = FIX_REGS + NB + NP,
  localparam int unsigned BW = AW - PB
) (
  input  logic [AW-1:0]          addr_i,
  input  logic                   mem_space_i,
  input  logic [2:0][AW-1:0]     mem_lo_i,
  input  logic [2:0][AW-1:0]     mem_hi_i,
  input  logic [2:0]             mem_en_i,
  input  logic [NB-1:0][AW-1:0]  dram_lo_i,
  input  logic [NB-1:0][AW-1:0]  dram_hi_i,
  input  logic [NB-1:0]          dram_en_i,
  input  logic [AW-1:0]          pcs_base_i,
  input  logic                   pcs_io_i,
  input  logic                   pcs_en_i,
  output logic [NR-1:0]          hit_o
);
  logic [BW-1:0] blk_off;
  logic          blk_above, pcs_space_ok;

  assign blk_above    = addr_i[AW-1:PB] >= pcs_base_i[AW-1:PB];
  assign blk_off      = addr_i[AW-1:PB] - pcs_base_i[AW-1:PB];
  assign pcs_space_ok = pcs_en_i && (mem_space_i != pcs_io_i);

  for (genvar r = 0; r < FIX_REGS; r++) begin : g_fix
    assign hit_o[r] = mem_space_i && mem_en_i[r] &&
                      in_window(addr_i, mem_lo_i[r], mem_hi_i[r]);
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit_o[FIX_REGS+b] = mem_space_i && dram_en_i[b] &&
                               in_window(addr_i, dram_lo_i[b], dram_hi_i[b]);
  end

  for (genvar k = 0; k < NP; k++) begin : g_pcs
    assign hit_o[FIX_REGS+NB+k] = pcs_space_ok && blk_above &&
                                  (blk_off == BW'(k));
  end
endmodule

// File: rtl/cs_resolve.sv
module cs_resolve import cs_dram_pkg::*; #(
  parameter int unsigned NB  = BANKS_D,
  parameter int unsigned NP  = PCS_D,
  parameter int unsigned WSW = WS_W_D,
  localparam int unsigned NR = FIX_REGS + NB + NP
) (
  input  logic [NR-1:0]          hit_i,
  input  logic                   addr_msb_i,
  input  logic                   mem_space_i,
  input  logic [1:0]             ben_i,
  input  logic [2:0][WSW-1:0]    mem_ws_i,
  input  logic [2:0]             mem_wide_i,
  input  logic                   io_wide_i,
  input  logic [NB-1:0][WSW-1:0] dram_ws_i,
  input  logic [NB-1:0]          dram_wide_i,
  input  logic [WSW-1:0]         pcs_ws_i,
  input  logic                   boot_wide_i,
  output logic [NR-1:0]          sel_o,
  output logic [1:0]             cas_o,
  output logic [WSW-1:0]         ws_o,
  output logic                   wide_o,
  output logic                   ovl_o,
  output logic                   err_o
);
  int n_fix, n_dram, n_pcs, win, d_idx, p_idx;
  logic any_hit, pair, usiz_eff, half_wide, space_wide;
  logic [WSW-1:0] pair_dram_ws;

  assign usiz_eff   = boot_wide_i | mem_wide_i[2];
  assign half_wide  = addr_msb_i ? usiz_eff : mem_wide_i[0];
  assign space_wide = mem_space_i ? half_wide : io_wide_i;

  always_comb begin
    n_fix = 0; n_dram = 0; n_pcs = 0;
    win = 0; d_idx = 0; p_idx = 0; any_hit = 1'b0;
    for (int i = NR-1; i >= 0; i--) begin
      if (hit_i[i]) begin win = i; any_hit = 1'b1; end
    end
    for (int i = 0; i < FIX_REGS; i++) if (hit_i[i]) n_fix++;
    for (int b = NB-1; b >= 0; b--) begin
      if (hit_i[FIX_REGS+b]) begin n_dram++; d_idx = b; end
    end
    for (int k = NP-1; k >= 0; k--) begin
      if (hit_i[FIX_REGS+NB+k]) begin n_pcs++; p_idx = k; end
    end
    pair = (n_fix == 0) && (n_dram == 1) && (n_pcs == 1);
    pair_dram_ws = '0;
    for (int b = 0; b < NB; b++) if (d_idx == b) pair_dram_ws = dram_ws_i[b];
  end

  always_comb begin
    sel_o = '0; cas_o = 2'b00; ws_o = '0; wide_o = space_wide;
    ovl_o = 1'b0; err_o = 1'b0;
    if (pair) begin
      sel_o[FIX_REGS+d_idx]    = 1'b1;
      sel_o[FIX_REGS+NB+p_idx] = 1'b1;
      wide_o = half_wide;
      if (pcs_ws_i < pair_dram_ws) begin
        err_o = 1'b1;
        ws_o  = pair_dram_ws;
      end else begin
        ws_o  = pcs_ws_i;
      end
    end else if (any_hit) begin
      sel_o[win] = 1'b1;
      ovl_o = (n_fix + n_dram + n_pcs) > 1;
      for (int i = 0; i < FIX_REGS; i++) begin
        if (win == i) begin
          ws_o   = mem_ws_i[i];
          wide_o = (i == 2) ? usiz_eff : mem_wide_i[i];
        end
      end
      for (int b = 0; b < NB; b++) begin
        if (win == FIX_REGS + b) begin
          ws_o   = dram_ws_i[b];
          wide_o = dram_wide_i[b];
          cas_o  = ben_i;
        end
      end
      if (win >= FIX_REGS + NB) ws_o = pcs_ws_i;
    end
  end
endmodule

// File: rtl/cs_dram_decoder.sv
module cs_dram_decoder import cs_dram_pkg::*; #(
  parameter int unsigned NB  = BANKS_D,
  parameter int unsigned NP  = PCS_D,
  parameter int unsigned PB  = PCS_BLK_D,
  parameter int unsigned WSW = WS_W_D,
  localparam int unsigned AW = ADDR_W_D,
  localparam int unsigned NR = FIX_REGS + NB + NP
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   boot_strap_i,
  input  logic [AW-1:0]          addr_i,
  input  logic                   mem_space_i,
  input  logic [1:0]             ben_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic                   ale_i,
  input  logic                   hold_ack_i,
  input  logic [2:0][AW-1:0]     mem_lo_i,
  input  logic [2:0][AW-1:0]     mem_hi_i,
  input  logic [2:0]             mem_en_i,
  input  logic [2:0][WSW-1:0]    mem_ws_i,
  input  logic [2:0]             mem_wide_i,
  input  logic                   io_wide_i,
  input  logic [NB-1:0][AW-1:0]  dram_lo_i,
  input  logic [NB-1:0][AW-1:0]  dram_hi_i,
  input  logic [NB-1:0]          dram_en_i,
  input  logic [NB-1:0][WSW-1:0] dram_ws_i,
  input  logic [NB-1:0]          dram_wide_i,
  input  logic [AW-1:0]          pcs_base_i,
  input  logic                   pcs_io_i,
  input  logic                   pcs_en_i,
  input  logic [WSW-1:0]         pcs_ws_i,
  output logic                   lcs_no,
  output logic                   mcs_no,
  output logic                   ucs_no,
  output logic [NP-1:0]          pcs_no,
  output logic [NB-1:0]          ras_no,
  output logic                   lcas_no,
  output logic                   ucas_no,
  output logic [WSW-1:0]         ws_o,
  output logic                   wide_o,
  output logic                   overlap_o,
  output logic                   cfg_err_o,
  output logic                   boot_wide_o
);
  logic [NR-1:0]  hit, sel_d, sel_q;
  logic [1:0]     cas_d, cas_q;
  logic [WSW-1:0] ws_d;
  logic           wide_d, ovl_d, err_d, strobe;

  cs_boot_latch u_boot (
    .clk_i, .rst_ni, .boot_strap_i, .boot_wide_o
  );

  cs_region_match #(.NB(NB), .NP(NP), .PB(PB)) u_match (
    .addr_i, .mem_space_i, .mem_lo_i, .mem_hi_i, .mem_en_i,
    .dram_lo_i, .dram_hi_i, .dram_en_i,
    .pcs_base_i, .pcs_io_i, .pcs_en_i,
    .hit_o (hit)
  );

  cs_resolve #(.NB(NB), .NP(NP), .WSW(WSW)) u_resolve (
    .hit_i       (hit),
    .addr_msb_i  (addr_i[AW-1]),
    .mem_space_i,
    .ben_i,
    .mem_ws_i, .mem_wide_i, .io_wide_i,
    .dram_ws_i, .dram_wide_i, .pcs_ws_i,
    .boot_wide_i (boot_wide_o),
    .sel_o (sel_d), .cas_o (cas_d), .ws_o (ws_d),
    .wide_o (wide_d), .ovl_o (ovl_d), .err_o (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0; cas_q <= '0; ws_o <= '0;
      wide_o <= 1'b0; overlap_o <= 1'b0; cfg_err_o <= 1'b0;
    end else if (ale_i && !hold_ack_i) begin
      sel_q <= sel_d; cas_q <= cas_d; ws_o <= ws_d;
      wide_o <= wide_d; overlap_o <= ovl_d; cfg_err_o <= err_d;
    end
  end

  assign strobe  = rd_i | wr_i;
  assign lcs_no  = ~sel_q[0] | hold_ack_i;
  assign mcs_no  = ~sel_q[1] | hold_ack_i;
  assign ucs_no  = ~sel_q[2] | hold_ack_i;
  assign ras_no  = ~sel_q[FIX_REGS +: NB] | {NB{hold_ack_i}};
  assign pcs_no  = ~sel_q[FIX_REGS+NB +: NP] | {NP{hold_ack_i}};
  assign lcas_no = ~(cas_q[0] & strobe) | hold_ack_i;
  assign ucas_no = ~(cas_q[1] & strobe) | hold_ack_i;
endmodule

// File: rtl/cs_dram_decoder_chk.sv
module cs_dram_decoder_chk #(
  parameter int unsigned NB  = 2,
  parameter int unsigned NP  = 4,
  parameter int unsigned WSW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ale_i,
  input logic           hold_ack_i,
  input logic           rd_i,
  input logic           wr_i,
  input logic           lcs_no,
  input logic           mcs_no,
  input logic           ucs_no,
  input logic [NP-1:0]  pcs_no,
  input logic [NB-1:0]  ras_no,
  input logic           lcas_no,
  input logic           ucas_no,
  input logic [WSW-1:0] ws_o,
  input logic           wide_o,
  input logic           overlap_o,
  input logic           cfg_err_o,
  input logic           boot_wide_o
);
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_i |-> (lcs_no && mcs_no && ucs_no && (&pcs_no) && (&ras_no)
                    && lcas_no && ucas_no));

  a_r4_pair_no_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&ras_no) && !(&pcs_no)) |-> (lcas_no && ucas_no));

  a_r7_one_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~lcs_no, ~mcs_no, ~ucs_no, ~pcs_no}));

  a_r3_cas_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lcas_no || !ucas_no) |-> ((rd_i || wr_i) && !hold_ack_i));

  a_r5_err_in_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !hold_ack_i) |-> (!(&ras_no) && !(&pcs_no)));

  a_r11_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ale_i) |-> ($stable(ws_o) && $stable(wide_o) &&
                       $stable(overlap_o) && $stable(cfg_err_o)));

  a_r9_boot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(boot_wide_o));
endmodule

bind cs_dram_decoder cs_dram_decoder_chk #(.NB(NB), .NP(NP), .WSW(WSW)) u_chk (
  .clk_i, .rst_ni, .ale_i, .hold_ack_i, .rd_i, .wr_i,
  .lcs_no, .mcs_no, .ucs_no, .pcs_no, .ras_no, .lcas_no, .ucas_no,
  .ws_o, .wide_o, .overlap_o, .cfg_err_o, .boot_wide_o
);

// File: tb/cs_dram_decoder_bench.sv
module cs_dram_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2, NP = 4, WSW = 4, AW = 20;
  localparam int NR = 3 + NB + NP;
  localparam int OW = 3 + NP + NB + 2;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic [AW-1:0] addr = '0;
  logic mem = 1'b1, rd = 1'b0, wr = 1'b0, ale = 1'b0, hold = 1'b0;
  logic [1:0] ben = 2'b11;
  logic [2:0][AW-1:0] mem_lo, mem_hi;
  logic [2:0] mem_en = 3'b111, mem_wide = 3'b011;
  logic [2:0][WSW-1:0] mem_ws;
  logic io_wide = 1'b0;
  logic [NB-1:0][AW-1:0] dram_lo, dram_hi;
  logic [NB-1:0] dram_en = 2'b11, dram_wide = 2'b11;
  logic [NB-1:0][WSW-1:0] dram_ws;
  logic [AW-1:0] pcs_base = 20'h20000;
  logic pcs_io = 1'b0, pcs_en = 1'b1;
  logic [WSW-1:0] pcs_ws = 4'd3;

  logic lcs_n, mcs_n, ucs_n, lcas_n, ucas_n, wide, ovl, err, boot;
  logic [NP-1:0] pcs_n;
  logic [NB-1:0] ras_n;
  logic [WSW-1:0] ws;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_dram_decoder u_cs_dram_decoder (
    .clk_i(clk), .rst_ni(rst_n), .boot_strap_i(strap), .addr_i(addr),
    .mem_space_i(mem), .ben_i(ben), .rd_i(rd), .wr_i(wr), .ale_i(ale),
    .hold_ack_i(hold), .mem_lo_i(mem_lo), .mem_hi_i(mem_hi),
    .mem_en_i(mem_en), .mem_ws_i(mem_ws), .mem_wide_i(mem_wide),
    .io_wide_i(io_wide), .dram_lo_i(dram_lo), .dram_hi_i(dram_hi),
    .dram_en_i(dram_en), .dram_ws_i(dram_ws), .dram_wide_i(dram_wide),
    .pcs_base_i(pcs_base), .pcs_io_i(pcs_io), .pcs_en_i(pcs_en),
    .pcs_ws_i(pcs_ws), .lcs_no(lcs_n), .mcs_no(mcs_n), .ucs_no(ucs_n),
    .pcs_no(pcs_n), .ras_no(ras_n), .lcas_no(lcas_n), .ucas_no(ucas_n),
    .ws_o(ws), .wide_o(wide), .overlap_o(ovl), .cfg_err_o(err),
    .boot_wide_o(boot)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // reference model: behavioural, integer windows
  bit [NR-1:0] e_sel;
  bit [1:0] e_cas;
  int e_ws;
  bit e_wide, e_ovl, e_err, e_boot;

  always @(posedge clk or negedge rst_n) begin : ref_model
    int lo, hi, nf, nd, np, total, win, di, pi;
    bit h [NR];
    bit uw, half;
    if (!rst_n) begin
      e_sel = '0; e_cas = 0; e_ws = 0; e_wide = 0; e_ovl = 0; e_err = 0;
      e_boot = strap;
    end else if (ale && !hold) begin
      for (int r = 0; r < 3; r++)
        h[r] = mem && mem_en[r] && addr >= mem_lo[r] && addr <= mem_hi[r];
      for (int b = 0; b < NB; b++)
        h[3+b] = mem && dram_en[b] && addr >= dram_lo[b] && addr <= dram_hi[b];
      for (int k = 0; k < NP; k++) begin
        lo = int'(pcs_base) / 256 * 256 + k * 256;
        hi = lo + 255;
        h[3+NB+k] = pcs_en && (mem == !pcs_io) && int'(addr) >= lo && int'(addr) <= hi;
      end
      nf = 0; nd = 0; np = 0; win = -1; di = -1; pi = -1;
      for (int i = 0; i < NR; i++) if (h[i]) begin
        if (win < 0) win = i;
        if (i < 3) nf++;
        else if (i < 3 + NB) begin nd++; if (di < 0) di = i - 3; end
        else begin np++; if (pi < 0) pi = i - 3 - NB; end
      end
      total = nf + nd + np;
      uw = e_boot || mem_wide[2];
      half = addr[AW-1] ? uw : mem_wide[0];
      e_sel = '0; e_cas = 0; e_ws = 0; e_ovl = 0; e_err = 0;
      e_wide = mem ? half : io_wide;
      if (nf == 0 && nd == 1 && np == 1) begin
        e_sel[3+di] = 1; e_sel[3+NB+pi] = 1; e_wide = half;
        if (pcs_ws < dram_ws[di]) begin e_err = 1; e_ws = dram_ws[di]; end
        else e_ws = pcs_ws;
      end else if (win >= 0) begin
        e_sel[win] = 1; e_ovl = total > 1;
        if (win == 2) begin e_ws = mem_ws[2]; e_wide = uw; end
        else if (win < 2) begin e_ws = mem_ws[win]; e_wide = mem_wide[win]; end
        else if (win < 3 + NB) begin
          e_ws = dram_ws[win-3]; e_wide = dram_wide[win-3]; e_cas = ben;
        end else e_ws = pcs_ws;
      end
    end
  end

  // R11 model comparison each cycle, away from edges
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      logic [OW-1:0] ea, aa;
      bit stb;
      stb = rd || wr;
      ea = {!e_sel[0] || hold, !e_sel[1] || hold, !e_sel[2] || hold,
            ~e_sel[3+NB +: NP] | {NP{hold}}, ~e_sel[3 +: NB] | {NB{hold}},
            !(e_cas[0] && stb) || hold, !(e_cas[1] && stb) || hold};
      aa = {lcs_n, mcs_n, ucs_n, pcs_n, ras_n, lcas_n, ucas_n};
      chk("R11 model selects", 32'(aa), 32'(ea));
      chk("R11 model ws", 32'(ws), 32'(e_ws));
      chk("R11 model flags", {28'd0, wide, ovl, err, boot},
          {28'd0, e_wide, e_ovl, e_err, e_boot});
    end
  end

  task automatic cyc(input logic [AW-1:0] a, input logic m, input logic [1:0] be,
                     input logic r, input logic w);
    @(negedge clk);
    addr = a; mem = m; ben = be; ale = 1'b1; rd = 1'b0; wr = 1'b0;
    @(negedge clk);
    ale = 1'b0; rd = r; wr = w;
    #1;
  endtask

  task automatic idle();
    @(negedge clk); rd = 1'b0; wr = 1'b0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
  endtask

  initial begin
    mem_lo[0] = 20'h00000; mem_hi[0] = 20'h1FFFF; mem_ws[0] = 4'd1;
    mem_lo[1] = 20'h40000; mem_hi[1] = 20'h4FFFF; mem_ws[1] = 4'd2;
    mem_lo[2] = 20'hE0000; mem_hi[2] = 20'hFFFFF; mem_ws[2] = 4'd3;
    dram_lo[0] = 20'h20000; dram_hi[0] = 20'h2FFFF; dram_ws[0] = 4'd2;
    dram_lo[1] = 20'h30000; dram_hi[1] = 20'h3FFFF; dram_ws[1] = 4'd1;

    repeat (2) @(negedge clk);
    chk("R12 reset selects", {lcs_n, mcs_n, ucs_n, &pcs_n, &ras_n, lcas_n, ucas_n}, 7'h7F);
    chk("R12 reset ws/wide", {ws, wide, ovl, err}, 0);
    do_reset(1'b0);
    chk("R9 strap low", boot, 0);

    cyc(20'h01000, 1, 2'b11, 1, 0);
    chk("R1 low region", {lcs_n, mcs_n, ucs_n}, 3'b011);
    chk("R6 low ws", ws, 1);
    chk("R6 low wide", wide, 1);
    idle();
    cyc(20'h1FFFF, 1, 2'b11, 1, 0);
    chk("R1 low upper bound", lcs_n, 0);
    idle();
    cyc(20'h50000, 1, 2'b11, 1, 0);
    chk("R1 above middle", {lcs_n, mcs_n, ucs_n, &pcs_n, &ras_n}, 5'h1F);
    chk("R6 no hit ws/wide", {ws, wide}, {4'd0, 1'b1});
    idle();

    cyc(20'h20400, 1, 2'b01, 0, 0);
    chk("R3 bank0 row", ras_n, 2'b10);
    chk("R3 no strobe no cas", {lcas_n, ucas_n}, 2'b11);
    wr = 1'b1; #1;
    chk("R3 low byte cas", {lcas_n, ucas_n}, 2'b01);
    chk("R6 dram ws/wide", {ws, wide}, {4'd2, 1'b1});
    idle();

    cyc(20'h20100, 1, 2'b11, 1, 0);
    chk("R2 pcs1", pcs_n, 4'b1101);
    chk("R4 row with pcs", ras_n, 2'b10);
    chk("R4 cas blocked", {lcas_n, ucas_n}, 2'b11);
    chk("R5 pcs ws", {ws, err, wide}, {4'd3, 1'b0, 1'b1});
    chk("R7 pair not flagged", ovl, 0);
    idle();

    @(negedge clk); pcs_ws = 4'd1;
    cyc(20'h20300, 1, 2'b11, 1, 0);
    chk("R2 pcs3", pcs_n, 4'b0111);
    chk("R5 cfg error", {ws, err}, {4'd2, 1'b1});
    idle(); pcs_ws = 4'd3;

    cyc(20'hF0000, 1, 2'b11, 1, 0);
    chk("R1 high region", ucs_n, 0);
    chk("R10 8-bit boot width cfg", {ws, wide}, {4'd3, 1'b0});
    idle();

    @(negedge clk); mem_lo[1] = 20'h10000;
    cyc(20'h18000, 1, 2'b11, 1, 0);
    chk("R7 lower wins", {lcs_n, mcs_n}, 2'b01);
    chk("R7 overlap flag", {ovl, ws}, {1'b1, 4'd1});
    idle(); mem_lo[1] = 20'h40000;

    cyc(20'h44000, 1, 2'b11, 1, 0);
    chk("R1 middle region", mcs_n, 0);
    @(negedge clk); rd = 1'b0; hold = 1'b1; #1;
    chk("R8 hold idle", {lcs_n, mcs_n, ucs_n, &pcs_n, &ras_n, lcas_n, ucas_n}, 7'h7F);
    cyc(20'h01000, 1, 2'b11, 0, 0);
    @(negedge clk); hold = 1'b0; #1;
    chk("R8 ale ignored in hold", {lcs_n, mcs_n}, 2'b10);

    @(negedge clk); pcs_io = 1'b1; pcs_base = 20'h00100;
    cyc(20'h00200, 0, 2'b11, 1, 0);
    chk("R2 io pcs1", pcs_n, 4'b1101);
    chk("R1 io no memory hit", lcs_n, 1);
    chk("R6 io width", {ws, wide}, {4'd3, 1'b0});
    idle();
    cyc(20'h00200, 1, 2'b11, 1, 0);
    chk("R2 io pcs ignores memory", {pcs_n, lcs_n}, 5'b11110);

    @(negedge clk); addr = 20'hF0000; mem_lo[0] = 20'h00500;
    repeat (2) @(negedge clk); #1;
    chk("R11 no ale no change", {lcs_n, ucs_n, ws}, {1'b0, 1'b1, 4'd1});
    idle(); mem_lo[0] = 20'h00000;

    do_reset(1'b1);
    chk("R9 strap high", boot, 1);
    chk("R12 reset after run", {lcs_n, ucs_n, ws, wide}, {1'b1, 1'b1, 4'd0, 1'b0});
    cyc(20'hF0000, 1, 2'b11, 1, 0);
    chk("R10 16-bit boot forces width", wide, 1);
    idle();
    cyc(20'h90000, 1, 2'b11, 1, 0);
    chk("R6 no hit upper half", {ws, wide}, {4'd0, 1'b1});
    idle();

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R12 watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule